// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block is the counting core of a real-time clock. It holds the time of day (seconds, minutes, hours) and the calendar (century, year, month, weekday, day of month) as packed BCD fields. A one-second tick input advances them. Carries ripple from seconds up to the century within the clock edge that takes the tick, so a reader never sees a half-finished increment.

Software reaches four word registers through a small register port: control, mode, time and calendar. To set the clock, software raises one or both hold bits in the control register. It then waits for the update acknowledge strobe, which arrives on the next second tick. Only after that does it write the time and/or calendar registers. Clearing the hold bits lets counting resume from the new values. Two strobe outputs, one per second advance and one for the acknowledge, feed an interrupt and status block that sits outside this core.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time register reads 0x00000000 (00:00:00) and the calendar register reads 0x01410019 (century 19, year 00, month 01, weekday 2, date 01). Control and mode read 0. Both strobes are low.
- R2: With time hold (control bit 0) clear, a tick sampled at a clock edge advances the seconds field in BCD at that edge. `sec_evt` is high for exactly the following cycle.
- R3: Time field layout is seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps and carries into hours. Hours 23 wraps to 00 and carries into the calendar.
- R4: Calendar field layout is century in bits 6:0, year in bits 15:8, month in bits 20:16, weekday in bits 23:21 and date in bits 29:24. On a day carry the weekday steps, with 7 wrapping to 1. The date wraps to 01 after the last day of the month (30 for months 04, 06, 09 and 11; 31 for the other months except February) and carries into the month. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century.
- R5: February has 29 days when the full year (century*100+year) is divisible by 4, except a year 00 whose century is not divisible by 4. Otherwise it has 28 days.
- R6: While control bit 0 is set, the time fields do not advance and `sec_evt` stays low. While control bit 1 is set, the calendar fields do not advance, and a day carry from the running time is dropped.
- R7: `upd_ack` pulses for one cycle on the first tick after a hold bit becomes set, and does not pulse again until both hold bits have been cleared.
- R8: A write to the time register takes effect only when control bit 0 is set and the acknowledge has occurred. The calendar register follows the same rule with control bit 1. Otherwise the write is ignored. Bit 22 of the time register always reads 0.
- R9: Clearing both hold bits resumes counting from the written values. Later writes to the time register are ignored.
- R10: The mode register bit 0 reads back what was written. Value 0 selects 24-hour operation, in which hours run 00 to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register index: 0 control, 1 mode, 2 time, 3 calendar |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register selected by `addr` |
| sec_evt | output | 1 | Seconds advanced in the previous edge |
| upd_ack | output | 1 | Update acknowledge, registers may now be written |

## Verification
The second-advance strobe and the update acknowledge can fire on the same tick. This happens when software holds only the calendar: the time keeps counting, so the tick that grants the acknowledge also advances the seconds. The bench provokes it by setting only control bit 1 before a tick. It then requires both strobes high in the one following cycle, the seconds to have moved, and a calendar write placed just after that tick to land while a time write is refused. A second case holds the calendar across midnight to confirm the dropped day carry.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        sec_evt,
  output logic        upd_ack
);

  logic [1:0] ctrl;
  logic       mode;
  logic       acked;
  logic [6:0] sec, mins, cent;
  logic [5:0] hr, date;
  logic [7:0] yr;
  logic [4:0] mon;
  logic [2:0] dow;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] sec_i, min_i, hr_i, date_i, mon_i, yr_i, cent_i;
  assign sec_i  = bcd_inc({1'b0, sec});
  assign min_i  = bcd_inc({1'b0, mins});
  assign hr_i   = bcd_inc({2'b0, hr});
  assign date_i = bcd_inc({2'b0, date});
  assign mon_i  = bcd_inc({3'b0, mon});
  assign yr_i   = bcd_inc(yr);
  assign cent_i = bcd_inc({1'b0, cent});

  logic [6:0] yr_bin, cent_bin;
  logic       leap;
  logic [5:0] month_end;
  assign yr_bin   = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};
  assign cent_bin = {4'b0, cent[6:4]} * 7'd10 + {3'b0, cent[3:0]};
  assign leap     = (yr == 8'h00) ? (cent_bin[1:0] == 2'b00) : (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (mon)
      5'h02:                      month_end = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_end = 6'h30;
      default:                    month_end = 6'h31;
    endcase
  end

  logic run_t, c_min, c_hr, c_day, c_mon, c_yr, c_cent;
  logic date_wrap;
  assign run_t     = tick_1hz & ~ctrl[0];
  assign c_min     = run_t & (sec == 7'h59);
  assign c_hr      = c_min & (mins == 7'h59);
  assign c_day     = c_hr & (hr == 6'h23) & ~ctrl[1];
  assign date_wrap = (date == month_end);
  assign c_mon     = c_day & date_wrap;
  assign c_yr      = c_mon & (mon == 5'h12);
  assign c_cent    = c_yr & (yr == 8'h99);

  logic wr_ctrl, wr_mode, wr_time, wr_cal;
  assign wr_ctrl = wr_en & (addr == 2'd0);
  assign wr_mode = wr_en & (addr == 2'd1);
  assign wr_time = wr_en & (addr == 2'd2) & ctrl[0] & acked;
  assign wr_cal  = wr_en & (addr == 2'd3) & ctrl[1] & acked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= 2'b00;
      mode    <= 1'b0;
      acked   <= 1'b0;
      sec_evt <= 1'b0;
      upd_ack <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= wdata[1:0];
      if (wr_mode) mode <= wdata[0];
      if (ctrl == 2'b00)         acked <= 1'b0;
      else if (tick_1hz)         acked <= 1'b1;
      upd_ack <= tick_1hz & (ctrl != 2'b00) & ~acked;
      sec_evt <= run_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= 7'h00;
      mins <= 7'h00;
      hr   <= 6'h00;
    end else if (wr_time) begin
      sec  <= wdata[6:0];
      mins <= wdata[14:8];
      hr   <= wdata[21:16];
    end else begin
      if (run_t) sec  <= (sec == 7'h59) ? 7'h00 : sec_i[6:0];
      if (c_min) mins <= (mins == 7'h59) ? 7'h00 : min_i[6:0];
      if (c_hr)  hr   <= (hr == 6'h23) ? 6'h00 : hr_i[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cent <= 7'h19;
      yr   <= 8'h00;
      mon  <= 5'h01;
      dow  <= 3'd2;
      date <= 6'h01;
    end else if (wr_cal) begin
      cent <= wdata[6:0];
      yr   <= wdata[15:8];
      mon  <= wdata[20:16];
      dow  <= wdata[23:21];
      date <= wdata[29:24];
    end else begin
      if (c_day) begin
        dow  <= (dow == 3'd7) ? 3'd1 : dow + 3'd1;
        date <= date_wrap ? 6'h01 : date_i[5:0];
      end
      if (c_mon)  mon  <= (mon == 5'h12) ? 5'h01 : mon_i[4:0];
      if (c_yr)   yr   <= (yr == 8'h99) ? 8'h00 : yr_i;
      if (c_cent) cent <= cent_i[6:0];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {30'b0, ctrl};
      2'd1:    rdata = {31'b0, mode};
      2'd2:    rdata = {9'b0, 1'b0, hr, 1'b0, mins, 1'b0, sec};
      default: rdata = {2'b0, date, dow, mon, yr, 1'b0, cent};
    endcase
  end

endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [1:0] ctrl,
  input logic       acked,
  input logic [6:0] sec,
  input logic [6:0] mins,
  input logic [5:0] hr,
  input logic       sec_evt,
  input logic       upd_ack
);

  AST_EVT_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |-> $past(tick_1hz)); // R2

  AST_EVT_MOVES_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |-> (sec != $past(sec))); // R2

  AST_HOLD_FREEZES_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !(wr_en && addr == 2'd2)) |=> $stable({hr, mins, sec})); // R6

  AST_HOLD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] |=> !sec_evt); // R6

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ack |-> ($past(ctrl) != 2'b00)); // R7

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ack |-> !$past(upd_ack)); // R7

  AST_EARLY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !acked && ctrl[0]) |=> $stable({hr, mins, sec})); // R8

endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .addr(addr),
  .ctrl(ctrl), .acked(acked), .sec(sec), .mins(mins), .hr(hr),
  .sec_evt(sec_evt), .upd_ack(upd_ack)
);

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        sec_evt, upd_ack;
  int total = 0;
  int bad = 0;

  bcd_rtc_core u0 (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata),
                   .sec_evt(sec_evt), .upd_ack(upd_ack));

  always #5 clk = ~clk;

  function automatic logic [31:0] tm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    return {10'b0, h[5:0], 1'b0, m[6:0], 1'b0, s[6:0]};
  endfunction

  function automatic logic [31:0] cal(input logic [7:0] c, input logic [7:0] y, input logic [7:0] mo,
                                      input logic [2:0] w, input logic [7:0] d);
    return {2'b0, d[5:0], w, mo[4:0], y, 1'b0, c[6:0]};
  endfunction

  localparam int NV = 13;
  localparam logic [127:0] VEC [NV] = '{
    {tm(0,0,0),          cal('h19,0,1,2,1),        tm(0,0,1),    cal('h19,0,1,2,1)},
    {tm(0,0,'h59),       cal('h19,0,1,2,1),        tm(0,1,0),    cal('h19,0,1,2,1)},
    {tm(0,'h59,'h59),    cal('h19,0,1,2,1),        tm(1,0,0),    cal('h19,0,1,2,1)},
    {tm('h19,'h59,'h59), cal('h19,0,1,2,1),        tm('h20,0,0), cal('h19,0,1,2,1)},
    {tm('h23,'h59,'h59), cal('h19,'h99,1,7,'h31),  tm(0,0,0),    cal('h19,'h99,2,1,1)},
    {tm('h23,'h59,'h59), cal('h20,'h21,4,6,'h30),  tm(0,0,0),    cal('h20,'h21,5,7,1)},
    {tm('h23,'h59,'h59), cal('h20,'h23,2,3,'h28),  tm(0,0,0),    cal('h20,'h23,3,4,1)},
    {tm('h23,'h59,'h59), cal('h20,'h24,2,4,'h28),  tm(0,0,0),    cal('h20,'h24,2,5,'h29)},
    {tm('h23,'h59,'h59), cal('h20,'h24,2,5,'h29),  tm(0,0,0),    cal('h20,'h24,3,6,1)},
    {tm('h23,'h59,'h59), cal('h19,0,2,3,'h28),     tm(0,0,0),    cal('h19,0,3,4,1)},
    {tm('h23,'h59,'h59), cal('h20,0,2,2,'h28),     tm(0,0,0),    cal('h20,0,2,3,'h29)},
    {tm('h23,'h59,'h59), cal('h19,'h99,'h12,6,'h31), tm(0,0,0),  cal('h20,0,1,7,1)},
    {tm(9,9,9),          cal('h19,0,1,2,1),        tm(9,9,'h10), cal('h19,0,1,2,1)}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick_once();
    tick_1hz = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic set_all(input logic [31:0] t, input logic [31:0] c);
    wr(2'd0, 32'd3);
    tick_once();
    wr(2'd2, t);
    wr(2'd3, c);
    wr(2'd0, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd2, v); check("R1 time", v, 32'h0);
    rd(2'd3, v); check("R1 calendar", v, 32'h01410019);
    rd(2'd0, v); check("R1 control", v, 32'h0);
    rd(2'd1, v); check("R1 mode", v, 32'h0);
    check("R1 strobes", {30'b0, sec_evt, upd_ack}, 32'h0);

    // R2 basic advance and one-cycle event
    tick_once();
    check("R2 evt high", {31'b0, sec_evt}, 32'h1);
    rd(2'd2, v); check("R2 seconds", v, tm(0,0,1));
    @(negedge clk);
    check("R2 evt low", {31'b0, sec_evt}, 32'h0);

    // R8 write before acknowledge is ignored
    wr(2'd0, 32'd1);
    wr(2'd2, tm(5,5,5));
    rd(2'd2, v); check("R8 early write", v, tm(0,0,1));
    // R6 R7 hold and acknowledge
    tick_once();
    check("R7 ack pulse", {31'b0, upd_ack}, 32'h1);
    check("R6 no evt while held", {31'b0, sec_evt}, 32'h0);
    rd(2'd2, v); check("R6 time held", v, tm(0,0,1));
    tick_once();
    check("R7 no second ack", {31'b0, upd_ack}, 32'h0);
    wr(2'd2, tm(5,5,5) | 32'h0040_0000);
    rd(2'd2, v); check("R8 time write, bit22 zero", v, tm(5,5,5));
    wr(2'd3, cal('h20,'h24,2,4,'h28));
    rd(2'd3, v); check("R8 calendar not held", v, 32'h01410019);
    // R9 release resumes, later write ignored
    wr(2'd0, 32'd0);
    tick_once();
    rd(2'd2, v); check("R9 resume", v, tm(5,5,6));
    wr(2'd2, 32'h0);
    rd(2'd2, v); check("R9 write after release", v, tm(5,5,6));

    // Coincidence: calendar-only hold, time keeps running (R6 R7)
    wr(2'd0, 32'd2);
    tick_once();
    check("R7 ack with evt", {30'b0, sec_evt, upd_ack}, 32'h3);
    rd(2'd2, v); check("R6 time runs under cal hold", v, tm(5,5,7));
    wr(2'd3, cal('h20,'h24,2,4,'h28));
    rd(2'd3, v); check("R8 calendar write", v, cal('h20,'h24,2,4,'h28));
    wr(2'd2, 32'h0);
    rd(2'd2, v); check("R8 time write refused", v, tm(5,5,7));
    wr(2'd0, 32'd0);

    // R10 mode readback
    wr(2'd1, 32'd1);
    rd(2'd1, v); check("R10 mode readback", v, 32'h1);
    wr(2'd1, 32'd0);
    rd(2'd1, v); check("R10 mode zero", v, 32'h0);

    // Table: R3 R4 R5 R10 carries
    for (int i = 0; i < NV; i++) begin
      set_all(VEC[i][127:96], VEC[i][95:64]);
      tick_once();
      check("R2 evt", {31'b0, sec_evt}, 32'h1);
      rd(2'd2, v); check("R3 R10 time carry", v, VEC[i][63:32]);
      rd(2'd3, v); check("R4 R5 calendar carry", v, VEC[i][31:0]);
    end

    // R6 calendar hold drops midnight carry
    set_all(tm('h23,'h59,'h59), cal('h20,'h24,2,4,'h28));
    wr(2'd0, 32'd2);
    tick_once();
    check("R7 ack", {31'b0, upd_ack}, 32'h1);
    rd(2'd2, v); check("R6 time wrapped", v, tm(0,0,0));
    rd(2'd3, v); check("R6 calendar frozen", v, cal('h20,'h24,2,4,'h28));
    wr(2'd0, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule